// File: doc/BRIEF.md
# Return-From-Interrupt Opcode Detector

This block watches the read side of an 8-bit processor bus. Its job is to spot the two-byte return-from-interrupt instruction (EDh followed by 4Dh) as it is fetched. Interrupt peripherals chained by priority use that event to hand priority back to lower-priority devices. Only opcode fetches take part in matching. An opcode fetch is a read cycle with the memory request and the fetch qualifier both active. Every such cycle is counted once, on the rising edge of the read strobe as seen by the block's synchronous clock.

Some processor variants fetch the two bytes a second time, directly after the first pair. When this refetch behaviour applies, the detector consumes the repeated pair as part of the same event and raises its acknowledge only after the fourth byte. The processor can switch off its own fetch qualifier through a control bit. While the repeated pair is awaited in that state, the block generates the qualifier itself toward the target and accepts those reads as fetches. Two configuration inputs cover both device revisions. One says whether the device refetches at all. The other says whether it refetches always or only while the qualifier is switched off.

Top module: `reti_detector`

## Requirements
- R1: While reset is asserted, and after it, until the first fetch: `reti_ack` and `refetch_busy` are 0 and `tgt_fetch` equals `cpu_fetch`. Reset assertion takes effect at once, and release takes effect synchronously.
- R2: With refetch not in effect, a fetch of EDh followed by a fetch of 4Dh raises `reti_ack` in the clock cycle after the edge that samples the 4Dh read.
- R3: A cycle counts only on a rising edge of `rd_strobe` with `mem_req` and the qualifier active. A read without the qualifier leaves the match state untouched. A strobe held high counts once.
- R4: Any fetched byte other than the awaited one sends the matcher back to idle with no acknowledge.
- R5: With refetch in effect, the pattern ED, 4D, ED, 4D on consecutive fetches yields exactly one acknowledge, after the fourth byte. `refetch_busy` is 1 from the first 4Dh until the repeated pair completes or fails.
- R6: With refetch in effect, if the repeated pair breaks off, no acknowledge is issued and `refetch_busy` returns to 0.
- R7: Refetch is in effect when `refetch_en`=1 and either `refetch_always`=1 or `fetch_suppress`=1. It is sampled when the first 4Dh is accepted.
- R8: While `refetch_busy`=1 and `fetch_suppress`=1, a read with `mem_req` drives `tgt_fetch`=1 even if `cpu_fetch`=0, and that read is matched as a fetch.
- R9: While `refetch_busy`=0, `tgt_fetch` equals `cpu_fetch`, and reads without `cpu_fetch` are not matched, whatever the value of `fetch_suppress`.
- R10: `reti_ack` is high for exactly one clock cycle per detected instruction.
- R11: An EDh fetched where 4Dh is awaited counts as a fresh first byte. ED, ED, 4D is therefore a match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_data | input | 8 | Processor data bus |
| mem_req | input | 1 | Memory request, active high |
| rd_strobe | input | 1 | Read strobe, active high |
| cpu_fetch | input | 1 | Opcode-fetch qualifier from the processor, active high |
| fetch_suppress | input | 1 | Processor control bit: its qualifier is switched off |
| refetch_en | input | 1 | The device refetches the opcode pair |
| refetch_always | input | 1 | 1: refetch always; 0: only while the qualifier is switched off |
| tgt_fetch | output | 1 | Fetch qualifier toward the target, synthesized during refetch |
| reti_ack | output | 1 | One-cycle pulse after a complete instruction |
| refetch_busy | output | 1 | The repeated opcode pair is awaited |

## Verification
Two things happen at the same clock edge when the final refetch byte is taken: the acknowledge rises, and the synthesized qualifier stops. The bench provokes this by running a refetch with the processor qualifier switched off. It keeps the read strobe and memory request high past that edge. Between edges it then expects `reti_ack`=1 together with `tgt_fetch`=0. A second coincidence comes from a read strobe held high across several edges while the repeated pair is awaited. Here the bench judges that the edge detector and the matcher count one byte and not several, by confirming that `refetch_busy` stays set.

// File: rtl/reti_det_pkg.sv
package reti_det_pkg;
  typedef enum logic [1:0] {
    ST_IDLE      = 2'd0,  // nothing matched
    ST_GOT_A     = 2'd1,  // first opcode byte seen
    ST_RF_WAIT_A = 2'd2,  // pair done, repeated first byte awaited
    ST_RF_WAIT_B = 2'd3   // repeated first byte seen, repeated second awaited
  } match_st_e;
endpackage

// File: rtl/reti_rst_sync.sv
module reti_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q[g] <= 1'b0;
      else if (g == 0) chain_q[g] <= 1'b1;
      else chain_q[g] <= chain_q[(g == 0) ? 0 : g-1];
    end
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/reti_fetch_strobe.sv
module reti_fetch_strobe (
  input  logic clk,
  input  logic rst_n,
  input  logic rd_strobe,
  input  logic mem_req,
  input  logic cpu_fetch,
  input  logic fetch_suppress,
  input  logic refetch_busy,
  output logic fetch_evt,
  output logic tgt_fetch
);
  logic rd_prev_q;
  logic rd_prev_d;
  logic synth_ok;
  logic qual_eff;
  logic rd_rise;

  // qualifier stands in for the processor only while the repeated pair is awaited
  assign synth_ok = refetch_busy & fetch_suppress;
  assign qual_eff = cpu_fetch | synth_ok;
  assign rd_rise  = rd_strobe & ~rd_prev_q;

  always_comb begin
    rd_prev_d = rd_strobe;
    fetch_evt = rd_rise & mem_req & qual_eff;
    tgt_fetch = cpu_fetch | (synth_ok & mem_req & rd_strobe);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_prev_q <= 1'b0;
    else        rd_prev_q <= rd_prev_d;
  end
endmodule

// File: rtl/reti_seq_match.sv
module reti_seq_match
  import reti_det_pkg::*;
#(
  parameter int              DATA_W = 8,
  parameter logic [DATA_W-1:0] OP_A = 8'hED,
  parameter logic [DATA_W-1:0] OP_B = 8'h4D
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fetch_evt,
  input  logic [DATA_W-1:0] bus_data,
  input  logic              refetch_mode,
  output logic              reti_ack,
  output logic              refetch_busy
);
  match_st_e st_q, st_d;
  logic      ack_q, ack_d;
  logic      is_a, is_b;

  assign is_a = (bus_data == OP_A);
  assign is_b = (bus_data == OP_B);

  always_comb begin
    st_d  = st_q;
    ack_d = 1'b0;
    if (fetch_evt) begin
      unique case (st_q)
        ST_IDLE: st_d = is_a ? ST_GOT_A : ST_IDLE;
        ST_GOT_A: begin
          if (is_b) begin
            if (refetch_mode) st_d = ST_RF_WAIT_A;
            else begin
              st_d  = ST_IDLE;
              ack_d = 1'b1;
            end
          end else if (is_a) st_d = ST_GOT_A;
          else               st_d = ST_IDLE;
        end
        ST_RF_WAIT_A: st_d = is_a ? ST_RF_WAIT_B : ST_IDLE;
        ST_RF_WAIT_B: begin
          if (is_b) begin
            st_d  = ST_IDLE;
            ack_d = 1'b1;
          end else if (is_a) st_d = ST_GOT_A;
          else               st_d = ST_IDLE;
        end
        default: st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      ack_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      ack_q <= ack_d;
    end
  end

  assign reti_ack     = ack_q;
  assign refetch_busy = (st_q == ST_RF_WAIT_A) || (st_q == ST_RF_WAIT_B);
endmodule

// File: rtl/reti_detector.sv
module reti_detector #(
  parameter int                DATA_W      = 8,
  parameter logic [DATA_W-1:0] OP_A        = 8'hED,
  parameter logic [DATA_W-1:0] OP_B        = 8'h4D,
  parameter int                SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] bus_data,
  input  logic              mem_req,
  input  logic              rd_strobe,
  input  logic              cpu_fetch,
  input  logic              fetch_suppress,
  input  logic              refetch_en,
  input  logic              refetch_always,
  output logic              tgt_fetch,
  output logic              reti_ack,
  output logic              refetch_busy
);
  logic core_rst_n;
  logic fetch_evt;
  logic refetch_mode;

  reti_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(core_rst_n)
  );

  assign refetch_mode = refetch_en & (refetch_always | fetch_suppress);

  reti_fetch_strobe u_strobe (
    .clk(clk), .rst_n(core_rst_n), .rd_strobe(rd_strobe), .mem_req(mem_req),
    .cpu_fetch(cpu_fetch), .fetch_suppress(fetch_suppress),
    .refetch_busy(refetch_busy), .fetch_evt(fetch_evt), .tgt_fetch(tgt_fetch)
  );

  reti_seq_match #(.DATA_W(DATA_W), .OP_A(OP_A), .OP_B(OP_B)) u_match (
    .clk(clk), .rst_n(core_rst_n), .fetch_evt(fetch_evt), .bus_data(bus_data),
    .refetch_mode(refetch_mode), .reti_ack(reti_ack), .refetch_busy(refetch_busy)
  );
endmodule

// File: rtl/reti_detector_chk.sv
module reti_detector_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [DATA_W-1:0] bus_data,
  input logic              mem_req,
  input logic              rd_strobe,
  input logic              cpu_fetch,
  input logic              fetch_suppress,
  input logic              refetch_en,
  input logic              refetch_always,
  input logic              tgt_fetch,
  input logic              reti_ack,
  input logic              refetch_busy
);
  assert_ack_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    reti_ack |=> !reti_ack);

  assert_ack_after_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
    reti_ack |-> $past(rd_strobe & mem_req));

  assert_ack_ends_refetch_R5: assert property (@(posedge clk) disable iff (!rst_n)
    reti_ack |-> !refetch_busy);

  assert_busy_from_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(refetch_busy) |-> $past(rd_strobe & mem_req));

  assert_busy_needs_mode_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(refetch_busy) |-> $past(refetch_en));

  assert_qual_passthru_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !refetch_busy |-> (tgt_fetch == cpu_fetch));
endmodule

bind reti_detector reti_detector_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/reti_detector_bench.sv
`timescale 1ns/1ps
module reti_detector_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] bus_data;
  logic       mem_req, rd_strobe, cpu_fetch;
  logic       fetch_suppress, refetch_en, refetch_always;
  logic       tgt_fetch, reti_ack, refetch_busy;
  int         errors = 0;
  int         checks = 0;

  always #10 clk = ~clk;

  reti_detector u_reti_detector (
    .clk(clk), .rst_n(rst_n), .bus_data(bus_data), .mem_req(mem_req),
    .rd_strobe(rd_strobe), .cpu_fetch(cpu_fetch), .fetch_suppress(fetch_suppress),
    .refetch_en(refetch_en), .refetch_always(refetch_always),
    .tgt_fetch(tgt_fetch), .reti_ack(reti_ack), .refetch_busy(refetch_busy)
  );

  // {req[7:0], cfg{en,always,suppress}[2:0], byte[7:0], fetch, exp_ack, exp_busy, pad[1:0]}
  localparam int NV = 33;
  localparam logic [23:0] VEC [NV] = '{
    {8'd2,  3'b000, 8'hED, 1'b1, 1'b0, 1'b0, 2'b0},  // R2
    {8'd2,  3'b000, 8'h4D, 1'b1, 1'b1, 1'b0, 2'b0},  // R2 ack
    {8'd3,  3'b000, 8'hED, 1'b1, 1'b0, 1'b0, 2'b0},  // R3
    {8'd3,  3'b000, 8'h00, 1'b0, 1'b0, 1'b0, 2'b0},  // R3 data read ignored
    {8'd3,  3'b000, 8'h4D, 1'b1, 1'b1, 1'b0, 2'b0},  // R3 ack
    {8'd4,  3'b000, 8'hED, 1'b1, 1'b0, 1'b0, 2'b0},  // R4
    {8'd4,  3'b000, 8'h12, 1'b1, 1'b0, 1'b0, 2'b0},  // R4 mismatch
    {8'd4,  3'b000, 8'h4D, 1'b1, 1'b0, 1'b0, 2'b0},  // R4 no ack from idle
    {8'd11, 3'b000, 8'hED, 1'b1, 1'b0, 1'b0, 2'b0},  // R11
    {8'd11, 3'b000, 8'hED, 1'b1, 1'b0, 1'b0, 2'b0},  // R11 restart
    {8'd11, 3'b000, 8'h4D, 1'b1, 1'b1, 1'b0, 2'b0},  // R11 ack
    {8'd5,  3'b110, 8'hED, 1'b1, 1'b0, 1'b0, 2'b0},  // R5
    {8'd5,  3'b110, 8'h4D, 1'b1, 1'b0, 1'b1, 2'b0},  // R5 busy
    {8'd5,  3'b110, 8'hED, 1'b1, 1'b0, 1'b1, 2'b0},  // R5
    {8'd5,  3'b110, 8'h4D, 1'b1, 1'b1, 1'b0, 2'b0},  // R5 single ack
    {8'd6,  3'b110, 8'hED, 1'b1, 1'b0, 1'b0, 2'b0},  // R6
    {8'd6,  3'b110, 8'h4D, 1'b1, 1'b0, 1'b1, 2'b0},  // R6
    {8'd6,  3'b110, 8'h00, 1'b1, 1'b0, 1'b0, 2'b0},  // R6 broken refetch
    {8'd6,  3'b110, 8'h4D, 1'b1, 1'b0, 1'b0, 2'b0},  // R6 no ack
    {8'd11, 3'b110, 8'hED, 1'b1, 1'b0, 1'b0, 2'b0},  // R11 refetch path
    {8'd11, 3'b110, 8'h4D, 1'b1, 1'b0, 1'b1, 2'b0},  // R11
    {8'd11, 3'b110, 8'hED, 1'b1, 1'b0, 1'b1, 2'b0},  // R11
    {8'd11, 3'b110, 8'hED, 1'b1, 1'b0, 1'b0, 2'b0},  // R11 ED as fresh first
    {8'd11, 3'b110, 8'h4D, 1'b1, 1'b0, 1'b1, 2'b0},  // R11
    {8'd11, 3'b110, 8'hED, 1'b1, 1'b0, 1'b1, 2'b0},  // R11
    {8'd11, 3'b110, 8'h4D, 1'b1, 1'b1, 1'b0, 2'b0},  // R11 ack
    {8'd7,  3'b100, 8'hED, 1'b1, 1'b0, 1'b0, 2'b0},  // R7 revision w/o suppress
    {8'd7,  3'b100, 8'h4D, 1'b1, 1'b1, 1'b0, 2'b0},  // R7 single pair acks
    {8'd7,  3'b101, 8'hED, 1'b1, 1'b0, 1'b0, 2'b0},  // R7 suppressed
    {8'd7,  3'b101, 8'h4D, 1'b1, 1'b0, 1'b1, 2'b0},  // R7 refetch now
    {8'd8,  3'b101, 8'hED, 1'b0, 1'b0, 1'b1, 2'b0},  // R8 synthesized fetch
    {8'd8,  3'b101, 8'h4D, 1'b0, 1'b1, 1'b0, 2'b0},  // R8 ack
    {8'd9,  3'b101, 8'hED, 1'b0, 1'b0, 1'b0, 2'b0}   // R9 no synth when idle
  };

  task automatic check(input string req, input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0b expected=%0b", req, what, act, exp);
    end
  endtask

  // start a read at a falling edge, hold it across 'hold' rising edges
  task automatic start_read(input logic [2:0] cfg, input logic [7:0] d,
                            input logic f, input int hold);
    @(negedge clk);
    {refetch_en, refetch_always, fetch_suppress} = cfg;
    bus_data = d; mem_req = 1'b1; rd_strobe = 1'b1; cpu_fetch = f;
    repeat (hold) @(negedge clk);
  endtask

  task automatic end_read();
    mem_req = 1'b0; rd_strobe = 1'b0; cpu_fetch = 1'b0;
    @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    rst_n = 1'b0; bus_data = '0; mem_req = 0; rd_strobe = 0; cpu_fetch = 0;
    fetch_suppress = 0; refetch_en = 0; refetch_always = 0;
    repeat (3) @(negedge clk);
    check("R1", reti_ack, 1'b0, "ack in reset");
    check("R1", refetch_busy, 1'b0, "busy in reset");
    cpu_fetch = 1'b1; #1;
    check("R1", tgt_fetch, 1'b1, "qualifier passthrough in reset");
    cpu_fetch = 1'b0; #1;
    check("R1", tgt_fetch, 1'b0, "qualifier passthrough low");
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1", reti_ack, 1'b0, "ack after release");

    for (int i = 0; i < NV; i++) begin
      logic [23:0] v;
      string rq;
      v = VEC[i];
      rq = $sformatf("R%0d", v[23:16]);
      start_read(v[15:13], v[12:5], v[4], 1);
      check(rq, reti_ack, v[3], $sformatf("ack vec %0d", i));
      check(rq, refetch_busy, v[2], $sformatf("busy vec %0d", i));
      end_read();
      if (v[3]) check("R10", reti_ack, 1'b0, $sformatf("pulse width vec %0d", i));
    end

    // R3: strobe held high counts once (busy survives a held 4Dh)
    start_read(3'b110, 8'hED, 1'b1, 1); end_read();
    start_read(3'b110, 8'h4D, 1'b1, 3);
    check("R3", refetch_busy, 1'b1, "held strobe counted once");
    end_read();
    start_read(3'b110, 8'hED, 1'b1, 1); end_read();
    start_read(3'b110, 8'h4D, 1'b1, 1);
    check("R3", reti_ack, 1'b1, "completion after held strobe");
    end_read();

    // R8: synthesized qualifier, and its end coinciding with ack
    start_read(3'b101, 8'hED, 1'b1, 1); end_read();
    start_read(3'b101, 8'h4D, 1'b1, 1); end_read();
    @(negedge clk);
    bus_data = 8'hED; mem_req = 1'b1; rd_strobe = 1'b1; cpu_fetch = 1'b0; #1;
    check("R8", tgt_fetch, 1'b1, "qualifier synthesized");
    @(negedge clk); end_read();
    @(negedge clk);
    bus_data = 8'h4D; mem_req = 1'b1; rd_strobe = 1'b1; #1;
    check("R8", tgt_fetch, 1'b1, "qualifier on last refetch byte");
    @(negedge clk);
    check("R8", reti_ack, 1'b1, "ack with synthesized fetches");
    check("R9", tgt_fetch, 1'b0, "synthesis ends with ack");
    end_read();

    // R9: suppress set but idle -> plain reads do not match
    start_read(3'b101, 8'hED, 1'b0, 1);
    check("R9", tgt_fetch, 1'b0, "no synthesis when idle");
    end_read();
    start_read(3'b101, 8'h4D, 1'b1, 1);
    check("R9", refetch_busy, 1'b0, "unqualified ED not matched");
    end_read();

    // R1: asynchronous reset mid-refetch
    start_read(3'b110, 8'hED, 1'b1, 1); end_read();
    start_read(3'b110, 8'h4D, 1'b1, 1); end_read();
    check("R5", refetch_busy, 1'b1, "busy before reset");
    rst_n = 1'b0; #1;
    check("R1", refetch_busy, 1'b0, "async reset clears busy");
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(negedge clk);
    start_read(3'b110, 8'h4D, 1'b1, 1);
    check("R1", reti_ack, 1'b0, "no leftover match after reset");
    end_read();

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule